// File: doc/BRIEF.md
# Two-Digit Decimal Adder with Digit Correction

This block adds two packed decimal operands of two digits each, plus a carry-in bit. It returns a two-digit packed decimal sum and a decimal carry-out. The block is purely combinational and has no clock. Each operand holds one decimal digit per 4-bit nibble, and the least significant digit sits in bits 3:0.

Every digit passes through two stages. In the first stage, a 4-bit binary adder forms a raw sum and a raw carry. A range detector then raises a correction flag when the raw carry is set or when the raw nibble is a code from 1010 to 1111. The second stage is another 4-bit adder. Its other operand is built from the flag placed on bits 1 and 2 only, so that operand is either six or zero, and its carry-in is held at zero. The flag of each digit is that digit's decimal carry into the next digit's first stage. The flag of the top digit drives the carry-out.

Operands must hold nibbles from 0 to 9. The result for any other nibble value is undefined. The digit count is a parameter, and its default is two.

Top module: `bcd2_adder`

## Requirements
- R1: With every operand nibble in the range 0 to 9, each nibble of `sum` is in the range 0 to 9.
- R2: A digit's correction flag is set exactly when its first-stage carry is 1, or when bit 3 of the raw nibble is 1 and at least one of bits 2 and 1 is 1. For valid digits this is the same as the digit total being 10 or more.
- R3: When a digit's flag is set, its output nibble equals the raw nibble plus 0110, taken modulo 16. The carry from the second stage is discarded.
- R4: The flag of the low digit is the carry-in of the high digit's first-stage adder.
- R5: `cout` equals the correction flag of the high digit.
- R6: For all valid operands and both values of `cin`, {`cout`,`sum`} is the decimal encoding of a + b + cin. Here `cout` is 1 exactly when that total is 100 or more, and `sum` holds the total modulo 100.
- R7: The inputs a = 0x99, b = 0x99, cin = 0 give sum = 0x98 and cout = 1.
- R8: The inputs a = 0x99, b = 0x66, cin = 0 give sum = 0x65 and cout = 1. The low raw nibble 1111 becomes 0101, and the high raw nibble 0000 with its carry becomes 0110.
- R9: When a digit's flag is clear, its output nibble equals its raw first-stage nibble unchanged.
- R10: `cin` enters the low digit's first-stage adder as a carry of one, so a = 0x00, b = 0x00, cin = 1 gives sum = 0x01 and cout = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | First operand, two packed decimal digits, low digit in bits 3:0 |
| b | input | 8 | Second operand, two packed decimal digits, low digit in bits 3:0 |
| cin | input | 1 | Carry into the low digit |
| sum | output | 8 | Packed decimal sum, low digit in bits 3:0 |
| cout | output | 1 | Decimal carry out of the high digit |

## Verification
Every result settles in the same cycle as its stimulus, because the adder has no register anywhere in its path. The bench drives the operands just after a rising clock edge. It then reads `sum` and `cout` at the following falling edge, so the whole ripple through both digits has settled before it compares. All 10,000 valid operand pairs are swept with both carry-in values. Seeded random vectors and the named corner cases follow. Each vector is split into low-digit, high-digit and carry checks, and each check is tagged with the requirement its input pattern exercises.

// File: rtl/bcd2_pkg.sv
`timescale 1ns/1ps
package bcd2_pkg;
  localparam int unsigned NIB_W = 4;

  typedef logic [NIB_W-1:0] nib_t;

  typedef struct packed {
    logic co;
    nib_t s;
  } nsum_t;

  // plain 4-bit binary addition with carry
  function automatic nsum_t nib_add(nib_t x, nib_t y, logic ci);
    logic [NIB_W:0] t;
    nsum_t r;
    t = {1'b0, x} + {1'b0, y} + {{NIB_W{1'b0}}, ci};
    r.co = t[NIB_W];
    r.s  = t[NIB_W-1:0];
    return r;
  endfunction

  // raw result out of decimal range: carried, or code 1010..1111
  function automatic logic out_of_range(nsum_t r);
    return r.co | (r.s[3] & (r.s[2] | r.s[1]));
  endfunction

  // second-stage operand: flag on bits 2 and 1, zero elsewhere
  function automatic nib_t fix_operand(logic f);
    return {1'b0, f, f, 1'b0};
  endfunction

  function automatic logic is_digit(nib_t x);
    return x <= 4'd9;
  endfunction
endpackage

// File: rtl/bcd2_nib_adder.sv
`timescale 1ns/1ps
module bcd2_nib_adder
  import bcd2_pkg::*;
(
  input  logic [3:0] x,
  input  logic [3:0] y,
  input  logic       ci,
  output logic [3:0] s,
  output logic       co
);
  nsum_t r;
  always_comb begin
    r  = nib_add(x, y, ci);
    s  = r.s;
    co = r.co;
  end
endmodule

// File: rtl/bcd2_fix_detect.sv
`timescale 1ns/1ps
module bcd2_fix_detect
  import bcd2_pkg::*;
(
  input  logic [3:0] raw_s,
  input  logic       raw_co,
  output logic       fix
);
  nsum_t r;
  always_comb begin
    r.s  = raw_s;
    r.co = raw_co;
    fix  = out_of_range(r);
  end
endmodule

// File: rtl/bcd2_digit.sv
`timescale 1ns/1ps
module bcd2_digit
  import bcd2_pkg::*;
(
  input  logic [3:0] da,
  input  logic [3:0] db,
  input  logic       dci,
  output logic [3:0] dsum,
  output logic       dco
);
  logic [3:0] raw_s;
  logic       raw_co;
  logic       fix_flag;
  logic [3:0] fix_b;
  logic       stage2_co;

  bcd2_nib_adder u_stage1 (
    .x (da), .y (db), .ci (dci), .s (raw_s), .co (raw_co)
  );

  bcd2_fix_detect u_detect (
    .raw_s (raw_s), .raw_co (raw_co), .fix (fix_flag)
  );

  assign fix_b = fix_operand(fix_flag);

  bcd2_nib_adder u_stage2 (
    .x (raw_s), .y (fix_b), .ci (1'b0), .s (dsum), .co (stage2_co)
  );

  assign dco = fix_flag;

  logic [4:0] dec_total;
  logic [4:0] raw_plus6;
  always_comb begin
    dec_total = {1'b0, da} + {1'b0, db} + {4'b0, dci};
    raw_plus6 = {1'b0, raw_s} + 5'd6;
    if (is_digit(da) && is_digit(db)) begin
      p_digit_valid_r1: assert (dsum <= 4'd9)
        else $error("R1 digit %0d out of range", dsum);
      p_flag_ten_r2: assert (fix_flag == (dec_total >= 5'd10))
        else $error("R2 flag %0b for total %0d", fix_flag, dec_total);
    end
    if (fix_flag) begin
      p_fix_six_r3: assert ({stage2_co, dsum} == raw_plus6)
        else $error("R3 corrected %0d from raw %0d", dsum, raw_s);
    end else begin
      p_fix_zero_r9: assert (dsum == raw_s && !stage2_co)
        else $error("R9 passthrough %0d from raw %0d", dsum, raw_s);
    end
  end
endmodule

// File: rtl/bcd2_adder.sv
`timescale 1ns/1ps
module bcd2_adder
  import bcd2_pkg::*;
#(
  parameter int unsigned DIGITS = 2,
  localparam int unsigned W = DIGITS * NIB_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [DIGITS:0] dcarry;
  assign dcarry[0] = cin;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    bcd2_digit u_dig (
      .da   (a[g*NIB_W +: NIB_W]),
      .db   (b[g*NIB_W +: NIB_W]),
      .dci  (dcarry[g]),
      .dsum (sum[g*NIB_W +: NIB_W]),
      .dco  (dcarry[g+1])
    );
  end

  assign cout = dcarry[DIGITS];

  // decimal value check across the whole carry chain (R4, R5, R6)
  function automatic int unsigned dec_val(logic [W-1:0] v);
    int unsigned acc;
    acc = 0;
    for (int i = DIGITS - 1; i >= 0; i--)
      acc = acc * 10 + int'(v[i*NIB_W +: NIB_W]);
    return acc;
  endfunction

  function automatic logic all_digits(logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      ok = ok & is_digit(v[i*NIB_W +: NIB_W]);
    return ok;
  endfunction

  int unsigned lim;
  int unsigned tot;
  int unsigned got;
  always_comb begin
    lim = 1;
    for (int i = 0; i < DIGITS; i++) lim = lim * 10;
    tot = dec_val(a) + dec_val(b) + int'(cin);
    got = dec_val(sum) + (cout ? lim : 0);
    if (all_digits(a) && all_digits(b)) begin
      p_decimal_total_r6: assert (got == tot)
        else $error("R6 total %0d expected %0d", got, tot);
      p_cout_range_r5: assert (cout == (tot >= lim))
        else $error("R5 cout %0b for total %0d", cout, tot);
    end
  end
endmodule

// File: tb/sim_bcd2_adder.sv
`timescale 1ns/1ps
module sim_bcd2_adder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [7:0] a, b, sum;
  logic cin, cout;

  bcd2_adder u0 (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [7:0] enc(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int dec(logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  task automatic chk(string req, int actual, int expect_v);
    n_cmp++;
    if (actual !== expect_v) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (a=%h b=%h cin=%0b)",
               req, actual, expect_v, a, b, cin);
    end
  endtask

  // drive after a rising edge, read at the falling edge: zero-latency block
  task automatic run(logic [7:0] xa, logic [7:0] xb, logic xc);
    int tot, lo, hi, lo_tot;
    @(posedge clk);
    a = xa; b = xb; cin = xc;
    @(negedge clk);
    tot    = dec(xa) + dec(xb) + int'(xc);
    lo_tot = int'(xa[3:0]) + int'(xb[3:0]) + int'(xc);
    lo     = lo_tot % 10;
    hi     = (tot / 10) % 10;
    if (lo_tot >= 10) chk("R3 low digit corrected", int'(sum[3:0]), lo);
    else              chk("R9 low digit unchanged", int'(sum[3:0]), lo);
    if (xa[7:4] == 0 && xb[7:4] == 0)
      chk("R4 low flag carried into high digit", int'(sum[7:4]), (lo_tot >= 10) ? 1 : 0);
    else
      chk("R2 high digit", int'(sum[7:4]), hi);
    chk("R5 cout", int'(cout), (tot >= 100) ? 1 : 0);
    chk("R6 decimal total", int'(cout) * 100 + dec(sum), tot);
    if (sum[3:0] > 9 || sum[7:4] > 9) chk("R1 digit range", 1, 0);
  endtask

  initial begin
    a = 8'h00; b = 8'h00; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 quiet start sum", int'(sum), 0);
    chk("R5 quiet start cout", int'(cout), 0);

    run(8'h99, 8'h99, 1'b0);
    chk("R7 99+99 sum", int'(sum), 'h98);
    chk("R7 99+99 cout", int'(cout), 1);
    run(8'h99, 8'h66, 1'b0);
    chk("R8 99+66 sum", int'(sum), 'h65);
    chk("R8 99+66 cout", int'(cout), 1);
    run(8'h00, 8'h00, 1'b1);
    chk("R10 cin into low digit", int'(sum), 'h01);
    chk("R10 cout", int'(cout), 0);
    run(8'h99, 8'h00, 1'b1);
    chk("R4 ripple 99+00+1 sum", int'(sum), 'h00);
    chk("R5 ripple 99+00+1 cout", int'(cout), 1);
    run(8'h08, 8'h08, 1'b0);
    chk("R2 raw carry 8+8 low", int'(sum[3:0]), 6);
    run(8'h05, 8'h05, 1'b0);
    chk("R2 exact ten low", int'(sum[3:0]), 0);

    for (int i = 0; i < 100; i++)
      for (int j = 0; j < 100; j++)
        for (int c = 0; c < 2; c++)
          run(enc(i), enc(j), c[0]);

    void'($urandom(32'd7919));
    for (int k = 0; k < 2000; k++)
      run(enc($urandom % 100), enc($urandom % 100), 1'($urandom % 2));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule